// File: doc/BRIEF.md
# Burst-Only Request Qualifier for a 32-Channel DMA Controller

This block sits between the peripherals and the channel arbiter of a 32-channel DMA controller. Each channel's peripheral presents two request lines. One asks for a single item and the other asks for a full burst. A per-channel burst-only bit decides which of the two lines may reach the arbiter. While the bit is clear, either line raises the channel's request. While the bit is set, the single-item line is masked. The qualified requests leave the block through a register, one clock after the inputs.

Software sets burst-only bits through a write-one-to-set port and clears them through a write-one-to-clear port. Both ports share one read view of the stored bits, and that view is combinational. The channel control logic supplies two values per channel: the count of items still to move, and the arbitration size as a log2 code.

Whenever a channel's remaining count is smaller than its arbitration size, the block drops that channel's burst-only bit by itself. The last partial burst then completes on single requests.

Top module: `dma_req_qualifier`

## Requirements
- R1: After reset every burst-only bit reads 0 and every qualified request output is 0.
- R2: A set-port write sets bit n on the next rising edge for each bit n written as 1. Bits written as 0 keep their value. The read port shows the stored bits combinationally.
- R3: A clear-port write clears bit n on the next rising edge for each bit n written as 1. Bits written as 0 keep their value.
- R4: When a set write and a clear write hit the same bit in the same cycle, the bit reads 0 afterwards.
- R5: A channel's bit is cleared on the next edge whenever its remaining count (11 bits, channel n at bits [11n+10:11n]) is below its arbitration size. The size is 2 to the power of its 4-bit code (channel n at bits [4n+3:4n]), and codes above 10 count as 10 (1024 items). This clear beats a simultaneous set write.
- R6: With a channel's bit at 0, its request output one clock later is the OR of its single and burst request inputs.
- R7: With a channel's bit at 1, its single request input is ignored: the request output one clock later equals its burst request input.
- R8: With no write and a remaining count at or above the arbitration size, a bit holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_we | input | 1 | Write strobe of the set port |
| set_wdata | input | 32 | Write-one-to-set data, bit n for channel n |
| clr_we | input | 1 | Write strobe of the clear port |
| clr_wdata | input | 32 | Write-one-to-clear data, bit n for channel n |
| burst_only | output | 32 | Read view of the burst-only bits |
| single_req | input | 32 | Single-item request per channel |
| burst_req | input | 32 | Burst request per channel |
| remaining | input | 352 | Remaining item count, 11 bits per channel |
| arb_log2 | input | 128 | Arbitration size code, 4 bits per channel |
| req_out | output | 32 | Registered qualified request per channel |

## Verification
A wrong stored bit shows up at the read port at once, and at the request output one clock later, where it either lets single requests through or blocks them. A faulty threshold in the automatic clear leaves a bit at 1 when the remaining count sits just below the size, or drops it just at the size. The bench therefore drives counts one below and exactly at several sizes, including the clamped code and code 0. Priority faults among clear, set and the automatic clear appear in the read view in the cycle after the colliding writes.

// File: rtl/dma_req_qualifier.sv
module dma_req_qualifier #(
  parameter int NCH      = 32,
  parameter int CNT_W    = 11,
  parameter int SZ_W     = 4,
  parameter int MAX_LOG2 = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_we,
  input  logic [NCH-1:0]       set_wdata,
  input  logic                 clr_we,
  input  logic [NCH-1:0]       clr_wdata,
  output logic [NCH-1:0]       burst_only,
  input  logic [NCH-1:0]       single_req,
  input  logic [NCH-1:0]       burst_req,
  input  logic [NCH*CNT_W-1:0] remaining,
  input  logic [NCH*SZ_W-1:0]  arb_log2,
  output logic [NCH-1:0]       req_out
);

  logic [NCH-1:0] ub;
  logic [NCH-1:0] auto_clr;
  logic [NCH-1:0] set_m, clr_m;

  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_ch
      logic [SZ_W-1:0]  lg, lg_c;
      logic [CNT_W:0]   thr;
      logic [CNT_W-1:0] rem;
      assign lg   = arb_log2[i*SZ_W +: SZ_W];
      assign rem  = remaining[i*CNT_W +: CNT_W];
      assign lg_c = (int'(lg) > MAX_LOG2) ? SZ_W'(MAX_LOG2) : lg;
      assign thr  = (CNT_W+1)'(1) << lg_c;
      assign auto_clr[i] = {1'b0, rem} < thr;
    end
  endgenerate

  assign set_m = set_we ? set_wdata : '0;
  assign clr_m = clr_we ? clr_wdata : '0;
  assign burst_only = ub;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ub      <= '0;
      req_out <= '0;
    end else begin
      ub      <= (ub | set_m) & ~clr_m & ~auto_clr;
      req_out <= burst_req | (single_req & ~ub);
    end
  end

  a_r2_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
    |(set_m & ~clr_m & ~auto_clr) |=> (ub & $past(set_m & ~clr_m & ~auto_clr)) == $past(set_m & ~clr_m & ~auto_clr));
  a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    |clr_m |=> (ub & $past(clr_m)) == '0);
  a_r5_auto_clear: assert property (@(posedge clk) disable iff (!rst_n)
    |auto_clr |=> (ub & $past(auto_clr)) == '0);
  a_r7_single_masked: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (req_out & ~$past(burst_req) & $past(ub)) == '0);
  a_r6_req_passes: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (~req_out & ($past(burst_req) | ($past(single_req) & ~$past(ub)))) == '0);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we && auto_clr == '0) |=> $stable(ub));

endmodule

// File: tb/tb_dma_req_qualifier.sv
module tb_dma_req_qualifier;
  localparam int CLK_P = 10;
  localparam int NCH = 32, CNT_W = 11, SZ_W = 4;

  typedef struct packed {
    logic [31:0] set_w, clr_w, sreq, breq, exp_ub, exp_req;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{32'h000000FF, 32'h0, 32'hFFFFFFFF, 32'h0, 32'h000000FF, 32'hFFFFFFFF},
    '{32'h0, 32'h0, 32'hFFFFFFFF, 32'h0, 32'h000000FF, 32'hFFFFFF00},
    '{32'h0000FF00, 32'h0000000F, 32'h0, 32'h000000F0, 32'h0000FFF0, 32'h000000F0},
    '{32'hF0000000, 32'hF0000000, 32'h0000FFFF, 32'h0, 32'h0000FFF0, 32'h0000000F},
    '{32'h0, 32'h0, 32'hAAAAAAAA, 32'h55555555, 32'h0000FFF0, 32'hFFFF555F},
    '{32'h0, 32'hFFFFFFFF, 32'h0, 32'h0, 32'h0, 32'h0}
  };

  logic clk = 0, rst_n = 0;
  logic set_we = 0, clr_we = 0;
  logic [NCH-1:0] set_wdata = '0, clr_wdata = '0, single_req = '0, burst_req = '0;
  logic [NCH*CNT_W-1:0] remaining;
  logic [NCH*SZ_W-1:0] arb_log2;
  logic [NCH-1:0] burst_only, req_out;
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  dma_req_qualifier dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] s, input logic [31:0] c);
    set_we = (s != 0); set_wdata = s; clr_we = (c != 0); clr_wdata = c;
  endtask

  initial begin
    #(CLK_P*5000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      remaining[c*CNT_W +: CNT_W] = 11'd2047;
      arb_log2[c*SZ_W +: SZ_W] = 4'd10;
    end
    single_req = '1; burst_req = '1;
    #(CLK_P*3);
    chk("R1 reset bits", burst_only, 32'h0);
    chk("R1 reset req", req_out, 32'h0);
    @(negedge clk); rst_n = 1;
    single_req = '0; burst_req = '0;
    step();

    for (int v = 0; v < 6; v++) begin
      wr(VEC[v].set_w, VEC[v].clr_w);
      single_req = VEC[v].sreq; burst_req = VEC[v].breq;
      step();
      chk("R2 R3 R4 R8 bits", burst_only, VEC[v].exp_ub);
      chk("R6 R7 req", req_out, VEC[v].exp_req);
    end
    wr(0, 0); single_req = '0; burst_req = '0;

    // R5: 15 < 16 blocks a simultaneous set of channel 3
    remaining[3*CNT_W +: CNT_W] = 11'd15; arb_log2[3*SZ_W +: SZ_W] = 4'd4;
    wr(32'h8, 0); step();
    chk("R5 auto beats set", burst_only, 32'h0);
    remaining[3*CNT_W +: CNT_W] = 11'd16; step();
    chk("R8 at size set works", burst_only, 32'h8);
    wr(0, 0); step();
    chk("R8 at size holds", burst_only, 32'h8);
    remaining[3*CNT_W +: CNT_W] = 11'd15; step();
    chk("R5 drop below size", burst_only, 32'h0);

    // R5 clamp: code 15 acts as 1024
    arb_log2[5*SZ_W +: SZ_W] = 4'd15; remaining[5*CNT_W +: CNT_W] = 11'd1024;
    wr(32'h20, 0); step();
    wr(0, 0); step();
    chk("R5 clamp at 1024 holds", burst_only, 32'h20);
    remaining[5*CNT_W +: CNT_W] = 11'd1023; step();
    chk("R5 clamp below 1024", burst_only, 32'h0);

    // R5 code 0: size 1
    arb_log2[7*SZ_W +: SZ_W] = 4'd0; remaining[7*CNT_W +: CNT_W] = 11'd1;
    wr(32'h80, 0); step();
    wr(0, 0); step();
    chk("R5 size1 count1 holds", burst_only, 32'h80);
    single_req = 32'h80; step();
    chk("R7 masked single", req_out, 32'h0);
    remaining[7*CNT_W +: CNT_W] = 11'd0; step();
    chk("R5 size1 count0 clears", burst_only, 32'h0);
    step();
    chk("R6 single after clear", req_out, 32'h80);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule